// File: doc/BRIEF.md
# Byte-Addressed Load-Store Unit

This block sits between a processor's memory instructions and a 32-bit data memory whose addresses count bytes. Each request carries an operation code, a base register value, a 16-bit signed displacement and, for stores, the register value to be written. The unit forms the effective address and decides which of the four byte lanes take part. For stores it drives per-lane write enables and lane-placed write data. For loads it returns either the whole word or one byte, sign-extended.

A static input chooses how byte offsets within a word map onto lanes: either the lowest address names the most significant lane, or it names the least significant lane. Word accesses whose address is not a multiple of four are refused. A refused store writes nothing, and a refused load returns zero with an error flag. A small word memory inside the block holds the data so that loads can see earlier stores.

Top module: `lsu_top`

## Requirements
- R1: The effective address `ea_o` equals `base_i` plus `disp_i` sign-extended to 32 bits, modulo 2^32, in the same cycle as the request.
- R2: `misalign_o` is high in the request cycle exactly when a word operation (`op_i` 2'b00 load word, 2'b10 store word) has `ea_o[1:0]` not equal to 0. Byte operations (`op_i` 2'b01 load byte, 2'b11 store byte) are never misaligned.
- R3: A misaligned store drives `byte_we_o` to 4'b0000 and leaves memory unchanged.
- R4: A misaligned load answers one cycle later with `rd_err_o` high and `rd_data_o` equal to 0.
- R5: An aligned word store drives `byte_we_o` to 4'b1111 and `lane_wdata_o` equal to `wr_data_i`.
- R6: A byte store raises exactly one enable bit `byte_we_o[L]` and copies `wr_data_i[7:0]` onto all four lanes of `lane_wdata_o`. Lane L covers bits 8L+7..8L. L is `ea_o[1:0]` when `big_endian_i` is 0 and 3 minus `ea_o[1:0]` when it is 1.
- R7: An aligned word load returns the stored 32-bit word unchanged for either endian setting. Memory words are indexed by `ea_o[5:2]` (16 words, higher bits ignored).
- R8: A byte load returns lane L of the addressed word (L chosen as in R6) sign-extended to 32 bits.
- R9: `rd_valid_o` is high in the cycle after a load request and low in every other cycle.
- R10: A load followed in the next cycle by a store to the same word returns the word as it was before that store.
- R11: After reset `rd_valid_o` is 0, all memory words read as 0, and `byte_we_o` is 0 whenever `req_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| big_endian_i | input | 1 | 1: lowest byte address is the most significant lane |
| req_i | input | 1 | Request valid this cycle |
| op_i | input | 2 | 00 load word, 01 load byte, 10 store word, 11 store byte |
| base_i | input | 32 | Base register value |
| disp_i | input | 16 | Signed displacement |
| wr_data_i | input | 32 | Store source value |
| ea_o | output | 32 | Effective byte address |
| misalign_o | output | 1 | Misaligned word access this cycle |
| byte_we_o | output | 4 | Per-lane write enables |
| lane_wdata_o | output | 32 | Lane-placed write data |
| rd_valid_o | output | 1 | Load response valid |
| rd_err_o | output | 1 | Load response refused as misaligned |
| rd_data_o | output | 32 | Load response data |

## Verification
A load response and a new store can occur in the same cycle. The memory is read at the load's clock edge while a store issued right behind it writes at the next edge. The bench stores a word, loads it, and in the immediately following cycle stores a different value to the same word. The response must carry the first value, and a later load must see the second. The bench also issues misaligned stores and loads back to back with byte traffic, and judges that the refusal neither writes memory nor disturbs the response of the neighbouring request.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int XLEN  = 32;
  localparam int DISPW = 16;
  localparam int LANES = XLEN / 8;
  localparam int LW    = $clog2(LANES);

  typedef enum logic [1:0] {
    OP_LDW = 2'b00,
    OP_LDB = 2'b01,
    OP_STW = 2'b10,
    OP_STB = 2'b11
  } lsu_op_e;

  function automatic logic [XLEN-1:0] calc_ea(input logic [XLEN-1:0] base,
                                              input logic [DISPW-1:0] disp);
    return base + {{(XLEN-DISPW){disp[DISPW-1]}}, disp};
  endfunction

  function automatic logic [LW-1:0] lane_of(input logic [LW-1:0] off, input logic big);
    return big ? ~off : off;
  endfunction

  function automatic logic [XLEN-1:0] sext_byte(input logic [7:0] b);
    return {{(XLEN-8){b[7]}}, b};
  endfunction
endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import lsu_pkg::*;
(
  input  logic [XLEN-1:0]  base_i,
  input  logic [DISPW-1:0] disp_i,
  input  logic             is_byte_i,
  input  logic             big_i,
  output logic [XLEN-1:0]  ea_o,
  output logic             misalign_o,
  output logic [LW-1:0]    lane_o
);
  always_comb begin
    ea_o       = calc_ea(base_i, disp_i);
    misalign_o = !is_byte_i && (ea_o[LW-1:0] != '0);
    lane_o     = lane_of(ea_o[LW-1:0], big_i);
  end
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane
  import lsu_pkg::*;
(
  input  logic            en_i,
  input  logic            is_byte_i,
  input  logic            misalign_i,
  input  logic [LW-1:0]   lane_i,
  input  logic [XLEN-1:0] data_i,
  output logic [LANES-1:0] we_o,
  output logic [XLEN-1:0]  wdata_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      we_o[g] = en_i && !misalign_i && (!is_byte_i || (lane_i == LW'(g)));
      wdata_o[8*g +: 8] = is_byte_i ? data_i[7:0] : data_i[8*g +: 8];
    end
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_pkg::*;
(
  input  logic [XLEN-1:0] word_i,
  input  logic            is_byte_i,
  input  logic            err_i,
  input  logic [LW-1:0]   lane_i,
  output logic [XLEN-1:0] data_o
);
  logic [XLEN-1:0] shifted;
  always_comb begin
    shifted = word_i >> {lane_i, 3'b000};
    if (err_i)          data_o = '0;
    else if (is_byte_i) data_o = sext_byte(shifted[7:0]);
    else                data_o = word_i;
  end
endmodule

// File: rtl/lsu_word_ram.sv
module lsu_word_ram
  import lsu_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IDXW  = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] we_i,
  input  logic [IDXW-1:0]  wr_idx_i,
  input  logic [XLEN-1:0]  wdata_i,
  input  logic             re_i,
  input  logic [IDXW-1:0]  rd_idx_i,
  output logic [XLEN-1:0]  rdata_o
);
  logic [XLEN-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      rdata_o <= '0;
    end else begin
      if (re_i) rdata_o <= mem_q[rd_idx_i];
      for (int l = 0; l < LANES; l++)
        if (we_i[l]) mem_q[wr_idx_i][8*l +: 8] <= wdata_i[8*l +: 8];
    end
  end
endmodule

// File: rtl/lsu_top.sv
module lsu_top
  import lsu_pkg::*;
#(
  parameter int DEPTH_WORDS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        big_endian_i,
  input  logic        req_i,
  input  logic [1:0]  op_i,
  input  logic [31:0] base_i,
  input  logic [15:0] disp_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] ea_o,
  output logic        misalign_o,
  output logic [3:0]  byte_we_o,
  output logic [31:0] lane_wdata_o,
  output logic        rd_valid_o,
  output logic        rd_err_o,
  output logic [31:0] rd_data_o
);
  localparam int IDXW = $clog2(DEPTH_WORDS);

  lsu_op_e op_w;
  logic    is_load_w, is_store_w, is_byte_w, load_fire_w, store_req_w;
  logic [LW-1:0]   lane_w;
  logic [IDXW-1:0] idx_w;
  logic [XLEN-1:0] ram_rdata_w;

  logic          rd_valid_q, rd_err_q, rd_byte_q;
  logic [LW-1:0] rd_lane_q;

  assign op_w        = lsu_op_e'(op_i);
  assign is_store_w  = op_i[1];
  assign is_load_w   = !op_i[1];
  assign is_byte_w   = (op_w == OP_LDB) || (op_w == OP_STB);
  assign load_fire_w = req_i && is_load_w;
  assign store_req_w = req_i && is_store_w;
  assign idx_w       = ea_o[IDXW+LW-1:LW];

  lsu_addr_gen u_addr (
    .base_i     (base_i),
    .disp_i     (disp_i),
    .is_byte_i  (is_byte_w),
    .big_i      (big_endian_i),
    .ea_o       (ea_o),
    .misalign_o (misalign_o),
    .lane_o     (lane_w)
  );

  lsu_store_lane u_store (
    .en_i       (store_req_w),
    .is_byte_i  (is_byte_w),
    .misalign_i (misalign_o),
    .lane_i     (lane_w),
    .data_i     (wr_data_i),
    .we_o       (byte_we_o),
    .wdata_o    (lane_wdata_o)
  );

  lsu_word_ram #(.DEPTH(DEPTH_WORDS), .IDXW(IDXW)) u_ram (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_i     (byte_we_o),
    .wr_idx_i (idx_w),
    .wdata_i  (lane_wdata_o),
    .re_i     (load_fire_w),
    .rd_idx_i (idx_w),
    .rdata_o  (ram_rdata_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_err_q   <= 1'b0;
      rd_byte_q  <= 1'b0;
      rd_lane_q  <= '0;
    end else begin
      rd_valid_q <= load_fire_w;
      if (load_fire_w) begin
        rd_err_q  <= misalign_o;
        rd_byte_q <= is_byte_w;
        rd_lane_q <= lane_w;
      end
    end
  end

  lsu_load_extract u_extract (
    .word_i    (ram_rdata_w),
    .is_byte_i (rd_byte_q),
    .err_i     (rd_err_q),
    .lane_i    (rd_lane_q),
    .data_o    (rd_data_o)
  );

  assign rd_valid_o = rd_valid_q;
  assign rd_err_o   = rd_err_q;
endmodule

// File: rtl/lsu_top_chk.sv
module lsu_top_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_i,
  input logic        is_load_w,
  input logic        is_store_w,
  input logic        is_byte_w,
  input logic        misalign_o,
  input logic [3:0]  byte_we_o,
  input logic        rd_valid_o,
  input logic        rd_err_o,
  input logic        rd_byte_q,
  input logic [31:0] rd_data_o
);
  p_byte_never_misaligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && is_byte_w) |-> !misalign_o);

  p_misalign_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && misalign_o) |-> (byte_we_o == 4'b0000));

  p_err_data_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && rd_err_o) |-> (rd_data_o == 32'h0));

  p_word_store_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && is_store_w && !is_byte_w && !misalign_o) |-> (byte_we_o == 4'b1111));

  p_byte_store_one_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && is_store_w && is_byte_w) |-> ($countones(byte_we_o) == 1));

  p_byte_load_sext_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && !rd_err_o && rd_byte_q) |-> (rd_data_o[31:8] == {24{rd_data_o[7]}}));

  p_resp_follows_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && is_load_w) |=> rd_valid_o);

  p_no_resp_without_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_i && is_load_w) |=> !rd_valid_o);

  p_idle_no_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |-> (byte_we_o == 4'b0000));
endmodule

bind lsu_top lsu_top_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_i      (req_i),
  .is_load_w  (is_load_w),
  .is_store_w (is_store_w),
  .is_byte_w  (is_byte_w),
  .misalign_o (misalign_o),
  .byte_we_o  (byte_we_o),
  .rd_valid_o (rd_valid_o),
  .rd_err_o   (rd_err_o),
  .rd_byte_q  (rd_byte_q),
  .rd_data_o  (rd_data_o)
);

// File: tb/lsu_top_bench.sv
`timescale 1ns/1ps
module lsu_top_bench;
  localparam logic [1:0] LDW = 2'b00, LDB = 2'b01, STW = 2'b10, STB = 2'b11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        big_endian_i = 1'b0;
  logic        req_i = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic [31:0] base_i = '0;
  logic [15:0] disp_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] ea_o, lane_wdata_o, rd_data_o;
  logic        misalign_o, rd_valid_o, rd_err_o;
  logic [3:0]  byte_we_o;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  lsu_top u_lsu_top (
    .clk(clk), .rst_n(rst_n), .big_endian_i(big_endian_i), .req_i(req_i),
    .op_i(op_i), .base_i(base_i), .disp_i(disp_i), .wr_data_i(wr_data_i),
    .ea_o(ea_o), .misalign_o(misalign_o), .byte_we_o(byte_we_o),
    .lane_wdata_o(lane_wdata_o), .rd_valid_o(rd_valid_o), .rd_err_o(rd_err_o),
    .rd_data_o(rd_data_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic [31:0] base,
                       input logic [15:0] disp, input logic [31:0] wd);
    @(negedge clk);
    req_i = 1'b1; op_i = op; base_i = base; disp_i = disp; wr_data_i = wd;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    req_i = 1'b0;
    #1;
  endtask

  function automatic logic [31:0] widen(input logic [7:0] b);
    logic [31:0] r;
    r = 32'(b);
    if (b >= 8'h80) r = r | 32'hFFFF_FF00;
    return r;
  endfunction

  function automatic int lane_pos(input int off, input logic big);
    return big ? (3 - off) : off;
  endfunction

  task automatic t_reset();
    chk("R11 rd_valid after reset", 32'(rd_valid_o), 0);
    chk("R11 byte_we idle", 32'(byte_we_o), 0);
    drive(LDW, 32'h0000_003C, 16'h0000, 0);
    idle();
    chk("R11 memory cleared", rd_data_o, 0);
    chk("R9 valid after load", 32'(rd_valid_o), 1);
    idle();
    chk("R9 valid drops", 32'(rd_valid_o), 0);
  endtask

  task automatic t_ea();
    drive(LDW, 32'h0000_0100, 16'hFFFC, 0);
    chk("R1 negative disp", ea_o, 32'h0000_00FC);
    drive(LDW, 32'h0000_1000, 16'h7FF0, 0);
    chk("R1 positive disp", ea_o, 32'h0000_8FF0);
    drive(LDB, 32'hFFFF_FFFF, 16'h0002, 0);
    chk("R1 wrap", ea_o, 32'h0000_0001);
    idle();
    idle();
  endtask

  task automatic t_word(input logic big);
    big_endian_i = big;
    drive(STW, 32'h0000_0004, 16'h0004, 32'h8122_3344);
    chk("R5 word store enables", 32'(byte_we_o), 32'hF);
    chk("R5 word store data", lane_wdata_o, 32'h8122_3344);
    chk("R2 aligned word", 32'(misalign_o), 0);
    drive(LDW, 32'h0000_0008, 16'h0000, 0);
    idle();
    chk("R7 word load", rd_data_o, 32'h8122_3344);
    chk("R7 no error", 32'(rd_err_o), 0);
  endtask

  task automatic t_bytes(input logic big, input logic [31:0] base);
    logic [7:0]  pat [4];
    logic [31:0] word_exp;
    pat[0] = 8'h91; pat[1] = 8'h22; pat[2] = 8'hB3; pat[3] = 8'h44;
    big_endian_i = big;
    word_exp = 0;
    for (int k = 0; k < 4; k++) begin
      drive(STB, base, 16'(k), {24'hABCDEF, pat[k]});
      chk("R6 byte enable lane", 32'(byte_we_o), 32'(1) << lane_pos(k, big));
      chk("R6 byte replicated", lane_wdata_o, {4{pat[k]}});
      chk("R2 byte not misaligned", 32'(misalign_o), 0);
      word_exp = word_exp | (32'(pat[k]) << (8 * lane_pos(k, big)));
    end
    drive(LDW, base, 16'h0000, 0);
    idle();
    chk("R7 assembled word", rd_data_o, word_exp);
    for (int k = 0; k < 4; k++) begin
      drive(LDB, base + 32'(k), 16'h0000, 0);
      idle();
      chk("R8 byte load sext", rd_data_o, widen(pat[k]));
    end
  endtask

  task automatic t_misalign();
    big_endian_i = 1'b0;
    drive(STW, 32'h0000_001F, 16'h0002, 32'hDEAD_BEEF);
    chk("R2 misaligned store flag", 32'(misalign_o), 1);
    chk("R3 no enables", 32'(byte_we_o), 0);
    drive(LDW, 32'h0000_0022, 16'h0000, 0);
    chk("R2 misaligned load flag", 32'(misalign_o), 1);
    drive(LDW, 32'h0000_0020, 16'h0000, 0);
    chk("R4 error flag", 32'(rd_err_o), 1);
    chk("R4 zero data", rd_data_o, 0);
    drive(LDB, 32'h0000_0023, 16'h0000, 0);
    chk("R2 byte at odd addr", 32'(misalign_o), 0);
    chk("R3 memory unchanged", rd_data_o, 32'h44B3_2291);
    chk("R4 error clears", 32'(rd_err_o), 0);
    idle();
    chk("R8 neighbour byte", rd_data_o, 32'h0000_0044);
  endtask

  task automatic t_overlap();
    big_endian_i = 1'b1;
    drive(STW, 32'h0000_0030, 16'h0000, 32'h1357_9BDF);
    drive(LDW, 32'h0000_0030, 16'h0000, 0);
    drive(STW, 32'h0000_0030, 16'h0000, 32'h2468_ACE0);
    chk("R10 load sees old word", rd_data_o, 32'h1357_9BDF);
    chk("R9 valid in overlap", 32'(rd_valid_o), 1);
    drive(LDB, 32'h0000_0030, 16'h0000, 0);
    idle();
    chk("R10 new word byte big", rd_data_o, 32'h0000_0024);
    idle();
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    t_reset();
    t_ea();
    t_word(1'b0);
    t_word(1'b1);
    t_bytes(1'b0, 32'h0000_0020);
    t_bytes(1'b1, 32'h0000_0024);
    t_misalign();
    t_overlap();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule